// File: doc/BRIEF.md
# Prioritized Instruction Prefetch Queue

This block sits between an instruction cache and its single main-memory line-fill port. Whenever software writes a branch register with a target, the front end hands the target's line address and the branch-register number to this block. The block keeps those requests in first-in first-out order in a queue with one slot per branch register. A sequential-fetch miss always reaches memory ahead of them. When a prefetch finishes, the block returns the branch-register number so the front end can set that register's ready flag.

The block also keeps a busy bit and a present bit for every cache line. A line is marked busy from the issue of its fill until the fill data returns, and it is marked present from then on. The lookup port answers a request at once if its line is present and not busy. A request to a busy line stays unanswered until the fill ends. Lines that are not being filled keep serving hits while memory is working.

Only one memory transaction is outstanding at a time. A queued prefetch whose line is already present, or already being filled, completes without a memory read. The queue is not expected to fill up. If it is full and a new request arrives, the new line address replaces the line address of the oldest entry with the same branch-register number. If no entry has that number, the request is discarded.

Top module: `prefetch_queue_top`

## Requirements
- R1: After reset no memory request is raised, no line is busy, neither completion pulse is high, and a lookup of any line is not answered.
- R2: A demand miss seen while idle raises `mem_req` with its line on `mem_line` in the next cycle. `mem_req` and `mem_line` hold until the cycle in which `mem_ack` is sampled high. `dm_done` is high for one cycle, in the cycle after `mem_rvalid` is sampled high.
- R3: When a demand miss and a queued prefetch both wait while the memory port is idle, the demand miss is issued first.
- R4: The line being filled reads busy on `line_busy[line]` from the cycle after the request is issued until `mem_rvalid` is sampled. The bit is clear in the cycle after that, and the line then counts as present.
- R5: A lookup with `rd_valid` high drives `rd_hit` high in the same cycle if its line is present and not busy. It does so even while another line is being filled. A lookup of a busy line gets `rd_hit` low until that line's fill completes.
- R6: A prefetch is issued one cycle after it is pushed if the port is idle and no demand miss waits. When its fill completes, `pf_done` is high for one cycle, in the cycle after `mem_rvalid`, with the request's 3-bit branch-register number on `pf_done_tag`.
- R7: Queued prefetches go to memory in the order they were pushed.
- R8: A prefetch of a line that is already present raises no `mem_req`. Its `pf_done` pulse, with its tag, appears two cycles after the push cycle.
- R9: No new `mem_req` is raised between the acceptance of a request and the completion of its fill.
- R10: The queue holds 8 entries. A push into a full queue does not add an entry. It replaces the line address of the oldest entry with the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_valid | input | 1 | Prefetch request valid for one cycle per request |
| pf_line_addr | input | 4 | Line address of the branch target |
| pf_tag | input | 3 | Branch-register number of the request |
| dm_valid | input | 1 | Demand miss pending; held until `dm_done` |
| dm_line_addr | input | 4 | Line address of the demand miss |
| rd_valid | input | 1 | Lookup request |
| rd_line_addr | input | 4 | Line address of the lookup |
| rd_hit | output | 1 | Lookup answered this cycle |
| mem_req | output | 1 | Line-fill read request |
| mem_line | output | 4 | Line address of the read |
| mem_ack | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Fill data has been written; transaction complete |
| line_busy | output | 16 | Per-line fill-in-progress bits |
| pf_done | output | 1 | Prefetch completed (one-cycle pulse) |
| pf_done_tag | output | 3 | Branch-register number of the completed prefetch |
| dm_done | output | 1 | Demand fill completed (one-cycle pulse) |

## Verification
The arbitration is tested first with a lone demand miss. It is then tested with a demand miss raised during a prefetch fill, while two more prefetches are already queued. The arrival order of `mem_line` values separates demand priority from plain queue order, and it exposes any request issued too early. Lookups of the line being filled and of an already present line, made during the fill, separate per-line busy tracking from a single global busy flag. A prefetch of a present line checks that the memory read is skipped. Filling the queue and then pushing one more request checks the overwrite of the oldest entry with the same tag, against both dropping and appending.

// File: rtl/pfq_pkg.sv
// Shared types for the prefetch queue block.
package pfq_pkg;
    // Memory-port sequencer states.
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_REQ  = 2'd1,
        ARB_FILL = 2'd2
    } arb_state_e;
endpackage

// File: rtl/pfq_queue.sv
// Shift-register FIFO of prefetch requests, one slot per branch register.
// Entry 0 is the oldest. A push into a full queue with no pop replaces the
// line address of the oldest entry that carries the same tag. If no entry
// carries that tag, the push is dropped.
// Assumes pop is only raised while the queue is not empty.
module pfq_queue #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 4,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              pop,
    output logic              head_valid,
    output logic [LINE_W-1:0] head_line,
    output logic [TAG_W-1:0]  head_tag
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [LINE_W-1:0] line_q [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [LINE_W-1:0] line_n [DEPTH];
    logic [TAG_W-1:0]  tag_n  [DEPTH];
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              match_hit;
    logic [IDX_W-1:0]  match_idx;

    // Find the oldest valid entry whose tag equals the incoming tag.
    always_comb begin
        match_hit = 1'b0;
        match_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if ((CNT_W'(i) < cnt_q) && (tag_q[i] == push_tag)) begin
                match_hit = 1'b1;
                match_idx = IDX_W'(i);
            end
        end
    end

    // Next queue contents: shift out the head on pop, then append or overwrite.
    always_comb begin
        line_n = line_q;
        tag_n  = tag_q;
        cnt_n  = cnt_q;
        if (pop && (cnt_q != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                line_n[i] = line_q[i+1];
                tag_n[i]  = tag_q[i+1];
            end
            cnt_n = cnt_q - 1'b1;
        end
        if (push) begin
            if (cnt_n < FULL_CNT) begin
                line_n[cnt_n[IDX_W-1:0]] = push_line;
                tag_n[cnt_n[IDX_W-1:0]]  = push_tag;
                cnt_n = cnt_n + 1'b1;
            end else if (match_hit) begin
                line_n[match_idx] = push_line;
            end
        end
    end

    // Register the queue state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else begin
            cnt_q  <= cnt_n;
            line_q <= line_n;
            tag_q  <= tag_n;
        end
    end

    assign head_valid = (cnt_q != '0);
    assign head_line  = line_q[0];
    assign head_tag   = tag_q[0];

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT); // R10
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL_CNT && push && !pop) |=> (cnt_q == FULL_CNT)); // R10
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid); // R7
endmodule

// File: rtl/pfq_lines.sv
// Per-line busy and present bits, and the lookup answer.
// A line turns busy when its fill is issued. It turns present and not busy
// when the fill completes. Assumes start and finish never fall in the same
// cycle (the sequencer keeps a single transaction in flight).
module pfq_lines #(
    parameter int LINE_W = 4,
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  logic              finish,
    input  logic [LINE_W-1:0] end_line,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_skip,
    input  logic              rd_valid,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_hit,
    output logic [NLINES-1:0] busy
);
    logic [NLINES-1:0] busy_q;
    logic [NLINES-1:0] present_q;

    // Set busy at issue; at completion clear busy and mark the line present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= '0;
            present_q <= '0;
        end else begin
            if (start) begin
                busy_q[start_line] <= 1'b1;
            end
            if (finish) begin
                busy_q[end_line]    <= 1'b0;
                present_q[end_line] <= 1'b1;
            end
        end
    end

    // A lookup is answered only for present lines that are not being filled.
    assign rd_hit     = rd_valid && present_q[rd_line] && !busy_q[rd_line];
    assign probe_skip = present_q[probe_line] || busy_q[probe_line];
    assign busy       = busy_q;

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_q)); // R9
    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q[$past(start_line)]); // R4
    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (busy_q == '0)); // R4
endmodule

// File: rtl/pfq_arb.sv
// Memory-port sequencer. While idle it grants a pending demand miss ahead of
// the queue head. A head whose line is present or busy completes at once.
// Otherwise the head is issued. One transaction at a time: the request is
// held until accepted, then the fill is awaited.
// Assumes dm_valid is held until dm_done and then dropped.
module pfq_arb #(
    parameter int LINE_W = 4,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dm_valid,
    input  logic [LINE_W-1:0] dm_line,
    input  logic              head_valid,
    input  logic [LINE_W-1:0] head_line,
    input  logic [TAG_W-1:0]  head_tag,
    input  logic              head_skip,
    output logic              pop,
    output logic              start,
    output logic [LINE_W-1:0] start_line,
    output logic              finish,
    output logic [LINE_W-1:0] end_line,
    output logic              mem_req,
    output logic [LINE_W-1:0] mem_line,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    output logic              pf_done,
    output logic [TAG_W-1:0]  pf_done_tag,
    output logic              dm_done
);
    import pfq_pkg::*;

    arb_state_e        state_q;
    logic [LINE_W-1:0] cur_line_q;
    logic [TAG_W-1:0]  cur_tag_q;
    logic              cur_pf_q;
    logic              pf_done_q, dm_done_q;
    logic [TAG_W-1:0]  done_tag_q;
    logic              idle, issue_dm, issue_pf;

    // Grant decisions for the idle cycle.
    always_comb begin
        idle       = (state_q == ARB_IDLE);
        issue_dm   = idle && dm_valid;
        pop        = idle && !dm_valid && head_valid;
        issue_pf   = pop && !head_skip;
        start      = issue_dm || issue_pf;
        start_line = issue_dm ? dm_line : head_line;
        finish     = (state_q == ARB_FILL) && mem_rvalid;
        end_line   = cur_line_q;
    end

    // Sequencer state, current transaction and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ARB_IDLE;
            cur_line_q <= '0;
            cur_tag_q  <= '0;
            cur_pf_q   <= 1'b0;
            pf_done_q  <= 1'b0;
            dm_done_q  <= 1'b0;
            done_tag_q <= '0;
        end else begin
            pf_done_q <= 1'b0;
            dm_done_q <= 1'b0;
            unique case (state_q)
                ARB_IDLE: begin
                    if (issue_dm) begin
                        state_q    <= ARB_REQ;
                        cur_line_q <= dm_line;
                        cur_pf_q   <= 1'b0;
                    end else if (issue_pf) begin
                        state_q    <= ARB_REQ;
                        cur_line_q <= head_line;
                        cur_tag_q  <= head_tag;
                        cur_pf_q   <= 1'b1;
                    end else if (pop) begin
                        pf_done_q  <= 1'b1;
                        done_tag_q <= head_tag;
                    end
                end
                ARB_REQ: begin
                    if (mem_ack) begin
                        state_q <= ARB_FILL;
                    end
                end
                ARB_FILL: begin
                    if (mem_rvalid) begin
                        state_q <= ARB_IDLE;
                        if (cur_pf_q) begin
                            pf_done_q  <= 1'b1;
                            done_tag_q <= cur_tag_q;
                        end else begin
                            dm_done_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign mem_req     = (state_q == ARB_REQ);
    assign mem_line    = cur_line_q;
    assign pf_done     = pf_done_q;
    assign pf_done_tag = done_tag_q;
    assign dm_done     = dm_done_q;

    AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && dm_valid) |=> (mem_req && !cur_pf_q)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line))); // R2
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_done && dm_done)); // R6
    AST_NO_REQ_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req); // R9
endmodule

// File: rtl/prefetch_queue_top.sv
// Prefetch queue top level. Connects the request FIFO, the per-line
// busy/present tracker and the memory-port sequencer.
// Assumes a single memory port with one transaction in flight.
module prefetch_queue_top #(
    parameter int NUM_BREGS = 8,
    parameter int LINE_W    = 4,
    parameter int TAG_W     = $clog2(NUM_BREGS),
    parameter int NLINES    = 1 << LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_valid,
    input  logic [LINE_W-1:0] pf_line_addr,
    input  logic [TAG_W-1:0]  pf_tag,
    input  logic              dm_valid,
    input  logic [LINE_W-1:0] dm_line_addr,
    input  logic              rd_valid,
    input  logic [LINE_W-1:0] rd_line_addr,
    output logic              rd_hit,
    output logic              mem_req,
    output logic [LINE_W-1:0] mem_line,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    output logic [NLINES-1:0] line_busy,
    output logic              pf_done,
    output logic [TAG_W-1:0]  pf_done_tag,
    output logic              dm_done
);
    logic              head_valid, head_skip, pop;
    logic [LINE_W-1:0] head_line;
    logic [TAG_W-1:0]  head_tag;
    logic              start, finish;
    logic [LINE_W-1:0] start_line, end_line;

    pfq_queue #(.DEPTH(NUM_BREGS), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (pf_valid),
        .push_line  (pf_line_addr),
        .push_tag   (pf_tag),
        .pop        (pop),
        .head_valid (head_valid),
        .head_line  (head_line),
        .head_tag   (head_tag)
    );

    pfq_lines #(.LINE_W(LINE_W), .NLINES(NLINES)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_line (start_line),
        .finish     (finish),
        .end_line   (end_line),
        .probe_line (head_line),
        .probe_skip (head_skip),
        .rd_valid   (rd_valid),
        .rd_line    (rd_line_addr),
        .rd_hit     (rd_hit),
        .busy       (line_busy)
    );

    pfq_arb #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .dm_valid    (dm_valid),
        .dm_line     (dm_line_addr),
        .head_valid  (head_valid),
        .head_line   (head_line),
        .head_tag    (head_tag),
        .head_skip   (head_skip),
        .pop         (pop),
        .start       (start),
        .start_line  (start_line),
        .finish      (finish),
        .end_line    (end_line),
        .mem_req     (mem_req),
        .mem_line    (mem_line),
        .mem_ack     (mem_ack),
        .mem_rvalid  (mem_rvalid),
        .pf_done     (pf_done),
        .pf_done_tag (pf_done_tag),
        .dm_done     (dm_done)
    );

    AST_HIT_NOT_DURING_OWN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && mem_req) |-> (rd_line_addr != mem_line)); // R5
endmodule

// File: tb/tb_prefetch_queue_top.sv
module tb_prefetch_queue_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pf_valid;
    logic [3:0] pf_line_addr;
    logic [2:0] pf_tag;
    logic       dm_valid;
    logic [3:0] dm_line_addr;
    logic       rd_valid;
    logic [3:0] rd_line_addr;
    logic       rd_hit;
    logic       mem_req;
    logic [3:0] mem_line;
    logic       mem_ack;
    logic       mem_rvalid;
    logic [15:0] line_busy;
    logic       pf_done;
    logic [2:0] pf_done_tag;
    logic       dm_done;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prefetch_queue_top dut (
        .clk(clk), .rst_n(rst_n),
        .pf_valid(pf_valid), .pf_line_addr(pf_line_addr), .pf_tag(pf_tag),
        .dm_valid(dm_valid), .dm_line_addr(dm_line_addr),
        .rd_valid(rd_valid), .rd_line_addr(rd_line_addr), .rd_hit(rd_hit),
        .mem_req(mem_req), .mem_line(mem_line), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .line_busy(line_busy),
        .pf_done(pf_done), .pf_done_tag(pf_done_tag), .dm_done(dm_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic lookup(input logic [3:0] line, input bit exp, input string req);
        rd_valid = 1'b1;
        rd_line_addr = line;
        #1;
        check(rd_hit == exp, req, "rd_hit", int'(rd_hit), int'(exp));
        rd_valid = 1'b0;
    endtask

    task automatic push_pf(input logic [3:0] line, input logic [2:0] tag);
        pf_valid = 1'b1;
        pf_line_addr = line;
        pf_tag = tag;
        step();
        pf_valid = 1'b0;
    endtask

    task automatic wait_req(input logic [3:0] line, input string req);
        for (int i = 0; i < 30; i++) begin
            if (mem_req) break;
            step();
        end
        check(mem_req == 1'b1, req, "mem_req raised", int'(mem_req), 1);
        check(mem_line == line, req, "mem_line", int'(mem_line), int'(line));
    endtask

    // Serves one fill: ack, one wait cycle, then completion; checks R4/R9 and done.
    task automatic serve(input logic [3:0] line, input bit is_pf,
                         input logic [2:0] tag, input string req);
        wait_req(line, req);
        check(line_busy[line] == 1'b1, "R4", "busy during request", int'(line_busy[line]), 1);
        mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        check(mem_req == 1'b0, "R9", "no request while filling", int'(mem_req), 0);
        mem_rvalid = 1'b1;
        step();
        mem_rvalid = 1'b0;
        check(line_busy[line] == 1'b0, "R4", "busy cleared after fill", int'(line_busy[line]), 0);
        if (is_pf) begin
            check(pf_done == 1'b1, "R6", "pf_done", int'(pf_done), 1);
            check(pf_done_tag == tag, "R6", "pf_done_tag", int'(pf_done_tag), int'(tag));
        end else begin
            check(dm_done == 1'b1, "R2", "dm_done", int'(dm_done), 1);
            dm_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        check(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
        check(line_busy == 16'h0, "R1", "line_busy after reset", int'(line_busy), 0);
        check(pf_done == 1'b0 && dm_done == 1'b0, "R1", "done after reset",
              int'(pf_done) + int'(dm_done), 0);
        lookup(4'd3, 1'b0, "R1");
    endtask

    task automatic t_demand();
        dm_valid = 1'b1;
        dm_line_addr = 4'd3;
        step();
        check(mem_req == 1'b1 && mem_line == 4'd3, "R2", "demand issued next cycle",
              int'(mem_line), 3);
        check(line_busy[3] == 1'b1, "R4", "busy set at issue", int'(line_busy[3]), 1);
        step();
        step();
        check(mem_req == 1'b1 && mem_line == 4'd3, "R2", "request held without ack",
              int'(mem_req), 1);
        lookup(4'd3, 1'b0, "R5");
        serve(4'd3, 1'b0, 3'd0, "R2");
        lookup(4'd3, 1'b1, "R5");
        step();
        check(dm_done == 1'b0, "R2", "dm_done single cycle", int'(dm_done), 0);
    endtask

    task automatic t_overlap();
        push_pf(4'd5, 3'd2);
        step();
        check(mem_req == 1'b1 && mem_line == 4'd5, "R6", "prefetch issued", int'(mem_line), 5);
        lookup(4'd3, 1'b1, "R5");
        lookup(4'd5, 1'b0, "R5");
        push_pf(4'd8, 3'd1);
        push_pf(4'd9, 3'd4);
        dm_valid = 1'b1;
        dm_line_addr = 4'd7;
        check(mem_req == 1'b1 && mem_line == 4'd5, "R2", "held with queue and demand waiting",
              int'(mem_line), 5);
        mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        check(mem_req == 1'b0, "R9", "demand waits during fill", int'(mem_req), 0);
        step();
        check(mem_req == 1'b0, "R9", "demand still waits", int'(mem_req), 0);
        lookup(4'd5, 1'b0, "R5");
        lookup(4'd3, 1'b1, "R5");
        mem_rvalid = 1'b1;
        step();
        mem_rvalid = 1'b0;
        check(pf_done == 1'b1 && pf_done_tag == 3'd2, "R6", "prefetch tag",
              int'(pf_done_tag), 2);
        lookup(4'd5, 1'b1, "R5");
        serve(4'd7, 1'b0, 3'd0, "R3");
        serve(4'd8, 1'b1, 3'd1, "R7");
        serve(4'd9, 1'b1, 3'd4, "R7");
    endtask

    task automatic t_skip();
        step();
        pf_valid = 1'b1;
        pf_line_addr = 4'd3;
        pf_tag = 3'd6;
        step();
        pf_valid = 1'b0;
        check(pf_done == 1'b0 && mem_req == 1'b0, "R8", "nothing one cycle after push",
              int'(pf_done), 0);
        step();
        check(pf_done == 1'b1 && pf_done_tag == 3'd6, "R8", "present line done",
              int'(pf_done_tag), 6);
        check(mem_req == 1'b0, "R8", "no memory read", int'(mem_req), 0);
        step();
        check(mem_req == 1'b0, "R8", "still no memory read", int'(mem_req), 0);
    endtask

    task automatic t_overflow();
        logic [3:0] order [8];
        order = '{4'd0, 4'd1, 4'd15, 4'd4, 4'd6, 4'd12, 4'd13, 4'd14};
        dm_valid = 1'b1;
        dm_line_addr = 4'd11;
        wait_req(4'd11, "R2");
        mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        push_pf(4'd0, 3'd0);
        push_pf(4'd1, 3'd1);
        push_pf(4'd2, 3'd2);
        push_pf(4'd4, 3'd3);
        push_pf(4'd6, 3'd4);
        push_pf(4'd12, 3'd5);
        push_pf(4'd13, 3'd6);
        push_pf(4'd14, 3'd7);
        push_pf(4'd15, 3'd2);
        check(mem_req == 1'b0, "R9", "no issue while demand fills", int'(mem_req), 0);
        mem_rvalid = 1'b1;
        step();
        mem_rvalid = 1'b0;
        check(dm_done == 1'b1, "R2", "demand done", int'(dm_done), 1);
        dm_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            serve(order[i], 1'b1, 3'(i), "R10");
        end
        repeat (5) step();
        check(mem_req == 1'b0, "R10", "queue held only 8 entries", int'(mem_req), 0);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pf_valid = 1'b0; pf_line_addr = '0; pf_tag = '0;
        dm_valid = 1'b0; dm_line_addr = '0;
        rd_valid = 1'b0; rd_line_addr = '0;
        mem_ack = 1'b0; mem_rvalid = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_demand();
        t_overlap();
        t_skip();
        t_overflow();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule